// File: doc/BRIEF.md
# Software-Driven Management Line Register Block

This block gives a processor direct control of a two-wire PHY management bus. Software produces every clock phase and every data bit by writing a control word. There is no hardware frame engine. One control word sets the management clock level, the drive enable of the bidirectional data line and the level to drive. A status word returns the level currently present on the data line. When the block drives the line, that level is the driven value. Otherwise it is the external pad level after a synchronizer.

Every change of the management clock that software causes produces a one-cycle edge strobe and a direction flag. Other logic on the chip can use them to follow the bit timing without watching the clock level itself. The register bus carries a byte address and an access size. Only aligned 32-bit accesses are accepted. Any other access returns an error pulse and changes nothing.

Top module: `mgmt_bitbang_regs`

## Requirements
- R1: While reset is held and just after it: `mgmt_clk` is 0, `mgmt_dat_oe` is 0, `mgmt_dat_o` is 0, `clk_edge` is 0, `bus_rdata` is 0 and `bus_err` is 0.
- R2: A word write to byte offset 0x28 sets `mgmt_clk` to wdata bit 2 and `mgmt_dat_oe` to wdata bit 1. Both take the new value in the cycle after the write.
- R3: `mgmt_dat_o` takes wdata bit 0 only on a control write with wdata bit 1 set. Every other cycle keeps the value it had.
- R4: `clk_edge` is high for exactly the one cycle after a control write that changes the `mgmt_clk` level. In that cycle `clk_rise` equals the new level (1 rising, 0 falling). A control write that leaves the level unchanged gives no strobe.
- R5: A word read of byte offset 0x2C returns the line level in bit 0 and zero in bits 31:1. The line level is `mgmt_dat_o` when `mgmt_dat_oe` is 1. Otherwise it is `mgmt_dat_i` delayed by SYNC_STAGES register stages.
- R6: A word read of byte offset 0x28 returns {clock, enable, drive} in bits 2:0 and zero in the bits above.
- R7: An access is a word only when `bus_size` is 2'b10 (2'b00 byte, 2'b01 half) and address bits 1:0 are 0. Any other access raises `bus_err` for the next cycle, returns zero read data and does not change the outputs.
- R8: Writes to any other offset, inside or outside the 0x5C-byte window, change nothing. Reads of them return zero with no error.
- R9: Read data appears in the cycle after the request. `bus_rdata` is zero in every cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 write, 0 read |
| bus_size | input | 2 | Access size: 00 byte, 01 half, 10 word |
| bus_addr | input | ADDR_W | Byte address within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_err | output | 1 | Access-size or alignment error, registered |
| mgmt_clk | output | 1 | Management clock level |
| mgmt_dat_o | output | 1 | Value driven on the data line |
| mgmt_dat_oe | output | 1 | Data line drive enable |
| mgmt_dat_i | input | 1 | Pad level of the data line |
| clk_edge | output | 1 | One-cycle strobe on a clock level change |
| clk_rise | output | 1 | Direction of the last strobe |

## Verification
The bench builds the block with ADDR_W = 8 and SYNC_STAGES = 2. An 8-bit address reaches both register offsets and offsets beyond the 0x5C window, so the bench exercises the unmapped-read and out-of-window paths. Two synchronizer stages give a short, known latency. The bench can therefore change the pad level, wait a counted number of cycles and see the status bit follow, and also see that the driven value takes precedence while the enable is set.

// File: rtl/mgmt_bb_pkg.sv
package mgmt_bb_pkg;

  localparam logic [31:0] OFS_CTRL   = 32'h28;
  localparam logic [31:0] OFS_STAT   = 32'h2C;
  localparam logic [31:0] WIN_BYTES  = 32'h5C;

  localparam logic [1:0]  SZ_WORD    = 2'b10;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_CTRL = 2'd1,
    TGT_STAT = 2'd2
  } target_e;

  // Accepted only for an aligned full-word access.
  function automatic logic word_ok(input logic [1:0] size, input logic [1:0] lo);
    return (size == SZ_WORD) && (lo == 2'b00);
  endfunction

  function automatic target_e map_target(input logic [31:0] a);
    if (a >= WIN_BYTES)      return TGT_NONE;
    else if (a == OFS_CTRL)  return TGT_CTRL;
    else if (a == OFS_STAT)  return TGT_STAT;
    else                     return TGT_NONE;
  endfunction

  // Level seen on the shared line: own drive wins over the pad.
  function automatic logic line_level(input logic oe, input logic drv, input logic pad);
    return oe ? drv : pad;
  endfunction

  function automatic logic [31:0] ctrl_word(input logic c, input logic oe, input logic d);
    return {29'd0, c, oe, d};
  endfunction

endpackage

// File: rtl/mbb_decode.sv
module mbb_decode
  import mgmt_bb_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              sel,
  input  logic              we,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  output logic              ctrl_wr,
  output logic              ctrl_rd,
  output logic              stat_rd,
  output logic              any_rd,
  output logic              bad_acc
);
  localparam int PAD_W = 32 - ADDR_W;

  logic [31:0] addr_ext;
  logic        ok;
  target_e     tgt;

  assign addr_ext = {{PAD_W{1'b0}}, addr};
  assign ok       = word_ok(size, addr[1:0]);
  assign tgt      = map_target(addr_ext);

  assign ctrl_wr  = sel && we  && ok && (tgt == TGT_CTRL);
  assign ctrl_rd  = sel && !we && ok && (tgt == TGT_CTRL);
  assign stat_rd  = sel && !we && ok && (tgt == TGT_STAT);
  assign any_rd   = sel && !we && ok;
  assign bad_acc  = sel && !ok;
endmodule

// File: rtl/mbb_ctrl_reg.sv
module mbb_ctrl_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [2:0] wbits,
  output logic       clk_lvl,
  output logic       oe,
  output logic       drv,
  output logic       edge_stb,
  output logic       rise
);
  logic clk_chg;

  assign clk_chg = wr && (wbits[2] != clk_lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_lvl  <= 1'b0;
      oe       <= 1'b0;
      drv      <= 1'b0;
      edge_stb <= 1'b0;
      rise     <= 1'b0;
    end else begin
      edge_stb <= clk_chg;
      if (wr) begin
        clk_lvl <= wbits[2];
        oe      <= wbits[1];
        if (wbits[1]) drv <= wbits[0];
      end
      if (clk_chg) rise <= wbits[2];
    end
  end
endmodule

// File: rtl/mbb_line_sync.sv
module mbb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mgmt_bitbang_regs.sv
module mgmt_bitbang_regs
  import mgmt_bb_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_err,
  output logic              mgmt_clk,
  output logic              mgmt_dat_o,
  output logic              mgmt_dat_oe,
  input  logic              mgmt_dat_i,
  output logic              clk_edge,
  output logic              clk_rise
);
  logic        ctrl_wr, ctrl_rd, stat_rd, any_rd, bad_acc;
  logic        pad_sync;
  logic        line_now;
  logic [31:0] rd_mux;
  logic        unused_wdata;

  assign unused_wdata = ^bus_wdata[31:3];

  mbb_decode #(.ADDR_W(ADDR_W)) u_dec (
    .sel(bus_sel), .we(bus_we), .size(bus_size), .addr(bus_addr),
    .ctrl_wr(ctrl_wr), .ctrl_rd(ctrl_rd), .stat_rd(stat_rd),
    .any_rd(any_rd), .bad_acc(bad_acc)
  );

  mbb_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(ctrl_wr), .wbits(bus_wdata[2:0]),
    .clk_lvl(mgmt_clk), .oe(mgmt_dat_oe), .drv(mgmt_dat_o),
    .edge_stb(clk_edge), .rise(clk_rise)
  );

  mbb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(mgmt_dat_i), .q(pad_sync)
  );

  assign line_now = line_level(mgmt_dat_oe, mgmt_dat_o, pad_sync);

  always_comb begin
    rd_mux = 32'd0;
    if (ctrl_rd)      rd_mux = ctrl_word(mgmt_clk, mgmt_dat_oe, mgmt_dat_o);
    else if (stat_rd) rd_mux = {31'd0, line_now};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= 32'd0;
      bus_err   <= 1'b0;
    end else begin
      bus_rdata <= any_rd ? rd_mux : 32'd0;
      bus_err   <= bad_acc;
    end
  end
endmodule

// File: rtl/mgmt_bitbang_regs_chk.sv
module mgmt_bitbang_regs_chk
  import mgmt_bb_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [1:0]        bus_size,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              bus_err,
  input logic              mgmt_clk,
  input logic              mgmt_dat_o,
  input logic              mgmt_dat_oe,
  input logic              clk_edge,
  input logic              clk_rise
);
  localparam int PAD_W = 32 - ADDR_W;

  logic [31:0] a32;
  logic        is_word, drv_load, stat_req;

  assign a32      = {{PAD_W{1'b0}}, bus_addr};
  assign is_word  = word_ok(bus_size, bus_addr[1:0]);
  assign drv_load = bus_sel && bus_we && is_word && (a32 == OFS_CTRL) && bus_wdata[1];
  assign stat_req = bus_sel && !bus_we && is_word && (a32 == OFS_STAT);

  p_edge_changes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clk_edge |-> (mgmt_clk != $past(mgmt_clk)));

  p_rise_matches_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clk_edge |-> (clk_rise == mgmt_clk));

  p_drive_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_load |=> $stable(mgmt_dat_o));

  p_bad_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !is_word) |=> (bus_err && (bus_rdata == 32'd0) &&
      $stable({mgmt_clk, mgmt_dat_oe, mgmt_dat_o})));

  p_stat_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stat_req |=> (bus_rdata[31:1] == 31'd0));

  p_idle_rdata_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |=> (bus_rdata == 32'd0 && !bus_err));
endmodule

bind mgmt_bitbang_regs mgmt_bitbang_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .bus_err(bus_err), .mgmt_clk(mgmt_clk),
  .mgmt_dat_o(mgmt_dat_o), .mgmt_dat_oe(mgmt_dat_oe),
  .clk_edge(clk_edge), .clk_rise(clk_rise)
);

// File: tb/mgmt_bitbang_regs_test.sv
module mgmt_bitbang_regs_test;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, we = 1'b0, pad = 1'b1;
  logic [1:0] size = 2'b10;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic err, mclk, mdo, moe, edg, rise;

  int vectors = 0;
  int miscompares = 0;

  always #10 clk = ~clk;  // 50 MHz

  mgmt_bitbang_regs #(.ADDR_W(AW), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we), .bus_size(size),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .bus_err(err),
    .mgmt_clk(mclk), .mgmt_dat_o(mdo), .mgmt_dat_oe(moe), .mgmt_dat_i(pad),
    .clk_edge(edg), .clk_rise(rise)
  );

  typedef struct packed {
    logic        s;
    logic        w;
    logic [1:0]  sz;
    logic [7:0]  a;
    logic [31:0] wd;
    logic [31:0] erd;
    logic        eerr;
    logic [2:0]  epins;  // {clk, oe, drive}
    logic        eedge;
    logic        erise;
    logic [7:0]  req;
  } vec_t;

  // Pad held at 1 during the table.
  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{1'b1,1'b1,2'b10,8'h28,32'h4,32'h0,1'b0,3'b100,1'b1,1'b1,8'd4}, // R2 rise
    '{1'b1,1'b1,2'b10,8'h28,32'h4,32'h0,1'b0,3'b100,1'b0,1'b1,8'd4}, // R4 no change
    '{1'b1,1'b1,2'b10,8'h28,32'h3,32'h0,1'b0,3'b011,1'b1,1'b0,8'd2}, // R2 fall
    '{1'b1,1'b1,2'b10,8'h28,32'h5,32'h0,1'b0,3'b101,1'b1,1'b1,8'd3}, // R3 hold
    '{1'b1,1'b0,2'b10,8'h2C,32'h0,32'h1,1'b0,3'b101,1'b0,1'b1,8'd5}, // R5 pad
    '{1'b1,1'b0,2'b10,8'h28,32'h0,32'h5,1'b0,3'b101,1'b0,1'b1,8'd6}, // R6
    '{1'b1,1'b1,2'b10,8'h28,32'h6,32'h0,1'b0,3'b110,1'b0,1'b1,8'd3}, // R3 load 0
    '{1'b1,1'b0,2'b10,8'h2C,32'h0,32'h0,1'b0,3'b110,1'b0,1'b1,8'd5}, // R5 drive wins
    '{1'b1,1'b1,2'b01,8'h28,32'h1,32'h0,1'b1,3'b110,1'b0,1'b1,8'd7}, // R7 half
    '{1'b1,1'b0,2'b00,8'h2C,32'h0,32'h0,1'b1,3'b110,1'b0,1'b1,8'd7}, // R7 byte
    '{1'b1,1'b1,2'b10,8'h29,32'h0,32'h0,1'b1,3'b110,1'b0,1'b1,8'd7}, // R7 misaligned
    '{1'b1,1'b1,2'b10,8'h10,32'h0,32'h0,1'b0,3'b110,1'b0,1'b1,8'd8}, // R8 write
    '{1'b1,1'b0,2'b10,8'h10,32'h0,32'h0,1'b0,3'b110,1'b0,1'b1,8'd8}, // R8 read
    '{1'b1,1'b0,2'b10,8'h60,32'h0,32'h0,1'b0,3'b110,1'b0,1'b1,8'd8}, // R8 window
    '{1'b0,1'b0,2'b10,8'h28,32'h0,32'h0,1'b0,3'b110,1'b0,1'b1,8'd9}, // R9 idle
    '{1'b1,1'b1,2'b10,8'h28,32'h0,32'h0,1'b0,3'b000,1'b1,1'b0,8'd4}  // R4 fall
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic w, input logic [1:0] sz,
                       input logic [7:0] a, input logic [31:0] wd);
    sel = s; we = w; size = sz; addr = a; wdata = wd;
    @(posedge clk);
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "pins in reset", {29'd0, mclk, moe, mdo}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "rdata/err/edge after reset", {rdata[30:0], err}, 32'd0);
    check("R1", "edge after reset", {31'd0, edg}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      string r;
      r = $sformatf("R%0d", TBL[i].req);
      drive(TBL[i].s, TBL[i].w, TBL[i].sz, TBL[i].a, TBL[i].wd);
      check(r, $sformatf("vec %0d rdata", i), rdata, TBL[i].erd);
      check(r, $sformatf("vec %0d err", i), {31'd0, err}, {31'd0, TBL[i].eerr});
      check(r, $sformatf("vec %0d pins", i), {29'd0, mclk, moe, mdo}, {29'd0, TBL[i].epins});
      check(r, $sformatf("vec %0d edge", i), {31'd0, edg}, {31'd0, TBL[i].eedge});
      if (TBL[i].eedge)
        check(r, $sformatf("vec %0d rise", i), {31'd0, rise}, {31'd0, TBL[i].erise});
    end

    // R4: strobe lasts exactly one cycle
    drive(1'b1, 1'b1, 2'b10, 8'h28, 32'h4);
    check("R4", "strobe set", {31'd0, edg}, 32'd1);
    @(negedge clk);
    check("R4", "strobe cleared", {31'd0, edg}, 32'd0);

    // R5: pad change visible after two sync stages, oe clear
    pad = 1'b0;
    repeat (3) @(negedge clk);
    drive(1'b1, 1'b0, 2'b10, 8'h2C, 32'h0);
    check("R5", "pad low through sync", rdata, 32'd0);
    pad = 1'b1;
    repeat (3) @(negedge clk);
    drive(1'b1, 1'b0, 2'b10, 8'h2C, 32'h0);
    check("R5", "pad high through sync", rdata, 32'd1);

    // R9: rdata returns to zero the cycle after a read
    @(negedge clk);
    check("R9", "rdata cleared", rdata, 32'd0);

    // R1: mid-run reset clears driven state
    drive(1'b1, 1'b1, 2'b10, 8'h28, 32'h7);
    check("R2", "all set", {29'd0, mclk, moe, mdo}, 32'd7);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "async reset pins", {29'd0, mclk, moe, mdo, edg}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    finish_run();
  end
endmodule